// File: doc/BRIEF.md
# Potentiometer Wiper and Data Register Bank

This block keeps the digital state behind a bank of four digitally controlled potentiometers. Each pot has a volatile wiper register, whose value sets the tap position, and four stored data registers that hold presets. A serial front end decodes host traffic into single-cycle commands. The bank carries those commands out: direct writes and reads of either register kind, a status read, single transfers between a pot's wiper and one of its presets, and broadcast transfers that move all four pots at once.

The stored registers are flip-flops that keep their contents across the synchronous reset. A busy timer stands in for the slow program cycle of real nonvolatile cells. Any accepted change to a stored register raises a write-in-progress flag for a parameterised number of clock cycles. A change requested while the flag is up is dropped and sets a sticky rejection flag. An active-low protect input blocks every change to the stored registers. At reset every wiper is loaded from preset 0 of its own pot.

Top module: `potbank_core`

## Requirements
- R1: While `rst` is high, each wiper register is loaded from preset 0 of its own pot, and `wip`, `rejected` and `rd_valid` clear. Presets keep their contents across reset. Before the first write, preset r of pot p holds (DR_SEED + 3*(4p+r)) mod 256.
- R2: Opcode 1 writes `cmd_data` into the wiper of pot `cmd_pot`, visible on `wiper` one cycle later. The other wipers and `wip` do not change.
- R3: Reads assert `rd_valid` one cycle after the command with the result on `rd_data`. Opcode 0 returns the wiper of `cmd_pot`. Opcode 2 returns preset `cmd_sel` of `cmd_pot`. Opcode 8 returns `wip` in bit 0 and zeros above it. In all other cycles `rd_valid` is 0.
- R4: Opcode 3 stores `cmd_data` into preset `cmd_sel` of pot `cmd_pot`, where `cmd_sel` 0, 1, 2 and 3 select presets 0, 1, 2 and 3. The new value is readable as soon as the command completes.
- R5: Opcode 4 loads the wiper of `cmd_pot` from its preset `cmd_sel`. Opcode 5 stores the wiper of `cmd_pot` into its preset `cmd_sel`.
- R6: Opcode 6 loads every wiper from its own pot's preset `cmd_sel`. Opcode 7 stores every wiper into its own pot's preset `cmd_sel`.
- R7: Each accepted preset change (opcode 3, 5 or 7) holds `wip` high for exactly BUSY_CYC cycles, starting in the cycle after the command. Wiper-only commands never raise `wip`.
- R8: While `wp_n` is 0, opcodes 3, 5 and 7 leave every preset unchanged and do not start a busy cycle. Wiper commands still take effect.
- R9: A preset change requested while `wip` is 1 is dropped and sets `rejected`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| cmd_pot | input | 2 | Pot index |
| cmd_sel | input | 2 | Preset index within the pot |
| cmd_data | input | 8 | Write data |
| wp_n | input | 1 | Active-low protect for preset changes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| wiper | output | 32 | All wiper registers, pot p in bits 8p+7..8p |
| wip | output | 1 | Preset write cycle in progress |
| rejected | output | 1 | Sticky: a preset change arrived while busy |

## Verification
Each pot gets a distinct value in direct writes and transfers, so a wrong pot index or a wrong preset index shows up as a mismatched byte rather than a coincidental match. The single transfers run with a nonzero preset index, which separates them from broadcast transfers and from accesses to preset 0. The wip window is sampled on its last high cycle and on its first low cycle, which catches an off-by-one in the timer. Protected writes and writes made while busy are followed by read-backs of the target preset. A second reset after a preset 0 change shows whether wipers reload from stored state or from a fixed constant.

// File: rtl/potbank_pkg.sv
`timescale 1ns/1ps
package potbank_pkg;
  typedef enum logic [3:0] {
    OP_RD_WCR  = 4'd0,
    OP_WR_WCR  = 4'd1,
    OP_RD_DR   = 4'd2,
    OP_WR_DR   = 4'd3,
    OP_LD_WCR  = 4'd4,
    OP_ST_DR   = 4'd5,
    OP_LD_ALL  = 4'd6,
    OP_ST_ALL  = 4'd7,
    OP_RD_STAT = 4'd8
  } op_e;
endpackage

// File: rtl/potbank_decode.sv
`timescale 1ns/1ps
module potbank_decode
  import potbank_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [3:0] cmd_op,
  input  logic       wp_n,
  input  logic       busy,
  output logic       dr_go,
  output logic       reject_set
);
  logic dr_req;
  always_comb begin
    dr_req     = cmd_valid && (cmd_op == OP_WR_DR || cmd_op == OP_ST_DR || cmd_op == OP_ST_ALL);
    dr_go      = dr_req && wp_n && !busy;
    reject_set = dr_req && wp_n && busy;
  end
endmodule

// File: rtl/potbank_busy.sv
`timescale 1ns/1ps
module potbank_busy #(
  parameter int BUSY_CYC = 20,
  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic reject_set,
  output logic wip,
  output logic rejected
);
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      wip      <= 1'b0;
      cnt      <= '0;
      rejected <= 1'b0;
    end else begin
      if (reject_set) rejected <= 1'b1;
      if (start) begin
        wip <= 1'b1;
        cnt <= CNT_W'(BUSY_CYC - 1);
      end else if (wip) begin
        if (cnt == '0) wip <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/potbank_regs.sv
`timescale 1ns/1ps
module potbank_regs
  import potbank_pkg::*;
#(
  parameter int NUM_POT = 4,
  parameter int NUM_DR  = 4,
  parameter int DATA_W  = 8,
  parameter int DR_SEED = 64,
  localparam int POT_W = $clog2(NUM_POT),
  localparam int SEL_W = $clog2(NUM_DR),
  localparam int DEPTH = NUM_POT * NUM_DR,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  input  logic [3:0]                cmd_op,
  input  logic [POT_W-1:0]          cmd_pot,
  input  logic [SEL_W-1:0]          cmd_sel,
  input  logic [DATA_W-1:0]         cmd_data,
  input  logic                      dr_go,
  input  logic                      wip,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_POT*DATA_W-1:0] wiper
);
  logic [DATA_W-1:0] dr_mem [DEPTH];
  logic [DATA_W-1:0] wcr    [NUM_POT];
  logic [IDX_W-1:0]  sel_idx;

  assign sel_idx = IDX_W'(int'(cmd_pot) * NUM_DR + int'(cmd_sel));

  // Preset storage: keeps its value across rst, seeded at configuration.
  initial begin
    for (int i = 0; i < DEPTH; i++) dr_mem[i] = DATA_W'(DR_SEED + 3 * i);
  end

  always_ff @(posedge clk) begin
    if (dr_go) begin
      case (cmd_op)
        OP_WR_DR: dr_mem[sel_idx] <= cmd_data;
        OP_ST_DR: dr_mem[sel_idx] <= wcr[cmd_pot];
        OP_ST_ALL:
          for (int p = 0; p < NUM_POT; p++)
            dr_mem[p * NUM_DR + int'(cmd_sel)] <= wcr[p];
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_POT; p++) begin : g_pot
    always_ff @(posedge clk) begin
      if (rst) begin
        wcr[p] <= dr_mem[p * NUM_DR];
      end else if (cmd_valid) begin
        if (cmd_op == OP_LD_ALL)
          wcr[p] <= dr_mem[p * NUM_DR + int'(cmd_sel)];
        else if (int'(cmd_pot) == p) begin
          if (cmd_op == OP_WR_WCR)      wcr[p] <= cmd_data;
          else if (cmd_op == OP_LD_WCR) wcr[p] <= dr_mem[sel_idx];
        end
      end
    end
    assign wiper[p*DATA_W +: DATA_W] = wcr[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_RD_WCR: begin rd_valid <= 1'b1; rd_data <= wcr[cmd_pot]; end
          OP_RD_DR:  begin rd_valid <= 1'b1; rd_data <= dr_mem[sel_idx]; end
          OP_RD_STAT: begin rd_valid <= 1'b1; rd_data <= DATA_W'(wip); end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/potbank_core.sv
`timescale 1ns/1ps
module potbank_core #(
  parameter int NUM_POT  = 4,
  parameter int NUM_DR   = 4,
  parameter int DATA_W   = 8,
  parameter int BUSY_CYC = 20,
  parameter int DR_SEED  = 64,
  localparam int POT_W = $clog2(NUM_POT),
  localparam int SEL_W = $clog2(NUM_DR)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  input  logic [3:0]                cmd_op,
  input  logic [POT_W-1:0]          cmd_pot,
  input  logic [SEL_W-1:0]          cmd_sel,
  input  logic [DATA_W-1:0]         cmd_data,
  input  logic                      wp_n,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_POT*DATA_W-1:0] wiper,
  output logic                      wip,
  output logic                      rejected
);
  logic dr_go, reject_set;

  potbank_decode u_decode (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wp_n(wp_n), .busy(wip),
    .dr_go(dr_go), .reject_set(reject_set)
  );

  potbank_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .start(dr_go), .reject_set(reject_set),
    .wip(wip), .rejected(rejected)
  );

  potbank_regs #(
    .NUM_POT(NUM_POT), .NUM_DR(NUM_DR), .DATA_W(DATA_W), .DR_SEED(DR_SEED)
  ) u_regs (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
    .dr_go(dr_go), .wip(wip), .rd_valid(rd_valid), .rd_data(rd_data),
    .wiper(wiper)
  );
endmodule

// File: rtl/potbank_chk.sv
`timescale 1ns/1ps
module potbank_chk
  import potbank_pkg::*;
#(
  parameter int NUM_POT = 4,
  parameter int NUM_DR  = 4,
  parameter int DATA_W  = 8,
  localparam int POT_W = $clog2(NUM_POT),
  localparam int SEL_W = $clog2(NUM_DR)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cmd_valid,
  input logic [3:0]                cmd_op,
  input logic [POT_W-1:0]          cmd_pot,
  input logic [DATA_W-1:0]         cmd_data,
  input logic                      wp_n,
  input logic                      rd_valid,
  input logic [NUM_POT*DATA_W-1:0] wiper,
  input logic                      wip,
  input logic                      rejected
);
  logic is_rd, is_drw;
  assign is_rd  = cmd_valid && (cmd_op == OP_RD_WCR || cmd_op == OP_RD_DR || cmd_op == OP_RD_STAT);
  assign is_drw = cmd_valid && (cmd_op == OP_WR_DR || cmd_op == OP_ST_DR || cmd_op == OP_ST_ALL);

  // R2
  wcr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WR_WCR) |=> wiper[$past(cmd_pot)*DATA_W +: DATA_W] == $past(cmd_data));

  // R3
  rd_valid_set_chk: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> rd_valid);

  // R3
  rd_valid_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> !rd_valid);

  // R7
  wip_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(is_drw && wp_n));

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (is_drw && !wp_n && !wip) |=> !wip);

  // R9
  reject_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rejected) && !$past(rst)) |-> rejected);
endmodule

bind potbank_core potbank_chk #(.NUM_POT(NUM_POT), .NUM_DR(NUM_DR), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pot(cmd_pot),
  .cmd_data(cmd_data), .wp_n(wp_n), .rd_valid(rd_valid), .wiper(wiper),
  .wip(wip), .rejected(rejected)
);

// File: tb/potbank_core_bench.sv
`timescale 1ns/1ps
module potbank_core_bench;
  localparam int BUSY = 20;
  localparam int SEED = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_pot = '0;
  logic [1:0] cmd_sel = '0;
  logic [7:0] cmd_data = '0;
  logic       wp_n = 1'b1;
  logic       rd_valid, wip, rejected;
  logic [7:0] rd_data;
  logic [31:0] wiper;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] m_dr [16];
  logic [7:0] m_wcr [4];

  always #2.5 clk = ~clk;

  potbank_core #(.BUSY_CYC(BUSY), .DR_SEED(SEED)) u_potbank_core (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pot(cmd_pot),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .wp_n(wp_n), .rd_valid(rd_valid),
    .rd_data(rd_data), .wiper(wiper), .wip(wip), .rejected(rejected)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] pot,
                       input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pot = pot; cmd_sel = sel; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int p = 0; p < 4; p++) m_wcr[p] = m_dr[p*4];
  endtask

  task automatic wait_idle();
    repeat (BUSY + 1) @(negedge clk);
  endtask

  task automatic chk_wipers(input string req);
    for (int p = 0; p < 4; p++) chk(req, wiper[p*8 +: 8], m_wcr[p]);
  endtask

  task automatic rd_dr(input string req, input int p, input int r);
    issue(4'd2, 2'(p), 2'(r), 8'h00);
    chk(req, {rd_valid, rd_data}, {1'b1, m_dr[p*4+r]});
  endtask

  task automatic t_reset();
    do_reset();
    chk_wipers("R1");
    chk("R1", {wip, rejected, rd_valid}, 3'b000);
  endtask

  task automatic t_wcr_write();
    issue(4'd1, 2'd2, 2'd0, 8'h3C); m_wcr[2] = 8'h3C;
    chk_wipers("R2");
    chk("R2", wip, 0);
    issue(4'd0, 2'd2, 2'd0, 8'h00);
    chk("R3", {rd_valid, rd_data}, {1'b1, 8'h3C});
    @(negedge clk);
    chk("R3", rd_valid, 0);
  endtask

  task automatic t_dr_write();
    issue(4'd3, 2'd1, 2'd3, 8'hC7); m_dr[7] = 8'hC7;
    chk("R7", wip, 1);
    issue(4'd8, 2'd0, 2'd0, 8'h00);
    chk("R3", {rd_valid, rd_data}, {1'b1, 8'h01});
    repeat (BUSY - 3) @(negedge clk);
    chk("R7", wip, 1);
    @(negedge clk);
    chk("R7", wip, 0);
    rd_dr("R4", 1, 3);
    rd_dr("R4", 1, 0);
  endtask

  task automatic t_single_xfer();
    issue(4'd4, 2'd1, 2'd3, 8'h00); m_wcr[1] = m_dr[7];
    chk_wipers("R5");
    chk("R5", wip, 0);
    issue(4'd1, 2'd3, 2'd0, 8'h9A); m_wcr[3] = 8'h9A;
    issue(4'd5, 2'd3, 2'd2, 8'h00); m_dr[14] = 8'h9A;
    wait_idle();
    rd_dr("R5", 3, 2);
    rd_dr("R5", 3, 1);
  endtask

  task automatic t_global();
    issue(4'd6, 2'd0, 2'd1, 8'h00);
    for (int p = 0; p < 4; p++) m_wcr[p] = m_dr[p*4+1];
    chk_wipers("R6");
    for (int p = 0; p < 4; p++) issue(4'd1, 2'(p), 2'd0, 8'(8'h10 + 8'(p) * 8'h21));
    for (int p = 0; p < 4; p++) m_wcr[p] = 8'(8'h10 + p * 8'h21);
    issue(4'd7, 2'd0, 2'd2, 8'h00);
    for (int p = 0; p < 4; p++) m_dr[p*4+2] = m_wcr[p];
    wait_idle();
    for (int p = 0; p < 4; p++) rd_dr("R6", p, 2);
  endtask

  task automatic t_protect();
    wp_n = 1'b0;
    issue(4'd3, 2'd0, 2'd1, 8'hEE);
    chk("R8", wip, 0);
    rd_dr("R8", 0, 1);
    issue(4'd7, 2'd0, 2'd3, 8'h00);
    chk("R8", wip, 0);
    for (int p = 0; p < 4; p++) rd_dr("R8", p, 3);
    issue(4'd1, 2'd0, 2'd0, 8'h5D); m_wcr[0] = 8'h5D;
    chk_wipers("R8");
    wp_n = 1'b1;
  endtask

  task automatic t_busy_reject();
    issue(4'd3, 2'd2, 2'd1, 8'h11); m_dr[9] = 8'h11;
    chk("R9", rejected, 0);
    issue(4'd3, 2'd2, 2'd1, 8'h22);
    chk("R9", rejected, 1);
    wait_idle();
    rd_dr("R9", 2, 1);
    chk("R9", rejected, 1);
  endtask

  task automatic t_reload();
    issue(4'd3, 2'd2, 2'd0, 8'hA5); m_dr[8] = 8'hA5;
    wait_idle();
    do_reset();
    chk_wipers("R1");
    chk("R1", {wip, rejected}, 2'b00);
    rd_dr("R1", 2, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_dr[i] = 8'(SEED + 3 * i);
    t_reset();
    t_wcr_write();
    t_dr_write();
    t_single_xfer();
    t_global();
    t_protect();
    t_busy_reject();
    t_reload();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog got=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule